// File: doc/BRIEF.md
# Two-Wire Bus Phase Strobe Generator

This block paces a two-wire serial master. It holds a small clock setting made of a mantissa and an exponent, divides the system clock by the product they select, and emits a one-cycle phase strobe at that rate. Ten strobes make one serial bit period. The serial engine that follows uses the strobes to place the start, stop, data and acknowledge edges. A running phase index and an end-of-bit pulse come with each strobe, so the engine does not need its own sub-bit counter.

The setting is loaded through a single write port. The exponent sits in the low three bits and the mantissa in the four bits above it. The divider is built in two stages. A power-of-two prescaler comes first, and a mantissa counter follows it. A static mode input selects how the exponent is read: either the prescaler divides by 2^(N+1), or it divides by 2^N. Writing the setting, or deasserting the enable, clears every counter. Timing then restarts from zero, so no shortened period can appear.

Top module: `twi_rate_gen`

## Requirements
- R1: While reset is held, phase_stb and period_stb are 0 and phase_idx is 0. After reset the setting holds M=0 and N=0, so in the default mode strobes come every 2 cycles.
- R2: A write takes N from cfg_wdata[2:0] and M from cfg_wdata[6:3]. Bit 7 has no effect on the strobe timing.
- R3: With alt_mode=0, consecutive strobes are exactly (M+1)*2^(N+1) clock cycles apart. This covers every M in 0..15 and N in 0..7.
- R4: With alt_mode=1, consecutive strobes are exactly (M+1)*2^N clock cycles apart. With M=0 and N=0 this gives a strobe on every cycle.
- R5: A write clears all counters and the phase sequence. There is no strobe in the cycle after the write. The first strobe comes on the D-th following clock edge at which enable is high and no write occurs, where D is the new divisor.
- R6: While enable is 0, phase_stb stays low and the counters stay cleared. After enable returns, the first strobe comes on the D-th edge with enable high.
- R7: phase_idx is valid while phase_stb is high. It runs 0,1,...,9 and then wraps, starting at 0 after any restart. period_stb is high exactly with the strobe whose index is 9.
- R8: One serial bit lasts 10*D cycles: consecutive period_stb pulses are that far apart. For M=15 and N=2 in the default mode this is 1280 cycles, which at 125 MHz is just under 100 kHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Serial engine enabled; when low, the counters are cleared |
| alt_mode | input | 1 | Static exponent base: 0 divides by 2^(N+1), 1 divides by 2^N |
| cfg_we | input | 1 | Write strobe for the clock setting |
| cfg_wdata | input | 8 | Setting: [2:0] exponent N, [6:3] mantissa M |
| phase_stb | output | 1 | One-cycle sub-bit phase strobe |
| phase_idx | output | 4 | Index 0..9 of the current strobe within the bit |
| period_stb | output | 1 | High with the last strobe of each bit |

## Verification
The bench builds the block with its default parameters: an 8-bit setting, a 3-bit exponent, a 4-bit mantissa and tenfold oversampling. This keeps the largest divisor at 4096 cycles. That is small enough to sweep every mantissa against the low exponents in both exponent modes, and to visit the high exponents at their extreme mantissas, the all-ones setting included. A cycle-by-cycle arithmetic model predicts every strobe, index and end-of-bit pulse. Writes and enable drops are placed in the middle of periods, so truncated-period hazards also lie within reach.

// File: rtl/twi_rate_pkg.sv
package twi_rate_pkg;
   // exponent interpretation selected by the static mode pin
   typedef enum logic {
      EXP_PLUS_ONE = 1'b0,
      EXP_DIRECT   = 1'b1
   } exp_base_e;

   // exponent field starts at bit 0, mantissa field sits directly above it
   localparam int unsigned EXP_LSB = 0;
endpackage

// File: rtl/twi_rate_prescale.sv
module twi_rate_prescale #(
   parameter int unsigned N_W    = 3,
   parameter bit          ALT_EN = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clr,
   input  logic           alt_mode,
   input  logic [N_W-1:0] exp_n,
   output logic           tick
);
   import twi_rate_pkg::*;

   localparam int unsigned E_W   = N_W + 1;
   localparam int unsigned CNT_W = (1 << N_W);

   logic [E_W-1:0]   shift;
   logic [CNT_W:0]   lim_full;
   logic [CNT_W-1:0] lim;
   logic [CNT_W-1:0] cnt_q;

   generate
      if (ALT_EN) begin : g_sel_base
         always_comb begin
            if (exp_base_e'(alt_mode) == EXP_DIRECT) shift = {1'b0, exp_n};
            else                                     shift = {1'b0, exp_n} + 1'b1;
         end
      end else begin : g_fixed_base
         logic unused_alt;
         assign unused_alt = alt_mode;
         assign shift = {1'b0, exp_n} + 1'b1;
      end
   endgenerate

   assign lim_full = ({{CNT_W{1'b0}}, 1'b1} << shift) - 1'b1;
   assign lim      = lim_full[CNT_W-1:0];
   assign tick     = ~clr & (cnt_q == lim);

   always_ff @(posedge clk) begin
      if (!rst_n || clr)  cnt_q <= '0;
      else if (tick)      cnt_q <= '0;
      else                cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/twi_rate_mant.sv
module twi_rate_mant #(
   parameter int unsigned M_W = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clr,
   input  logic           tick,
   input  logic [M_W-1:0] mant,
   output logic           term
);
   logic [M_W-1:0] cnt_q;

   assign term = tick & (cnt_q == mant);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) cnt_q <= '0;
      else if (term)     cnt_q <= '0;
      else if (tick)     cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/twi_rate_phase.sv
module twi_rate_phase #(
   parameter int unsigned OVERSAMPLE = 10,
   parameter int unsigned PH_W       = $clog2(OVERSAMPLE)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            term,
   output logic            stb,
   output logic [PH_W-1:0] idx,
   output logic            last
);
   localparam logic [PH_W-1:0] LAST_IDX = PH_W'(OVERSAMPLE - 1);

   logic [PH_W-1:0] seq_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seq_q <= '0;
         stb   <= 1'b0;
         idx   <= '0;
         last  <= 1'b0;
      end else if (clr) begin
         seq_q <= '0;
         stb   <= 1'b0;
         last  <= 1'b0;
      end else begin
         stb  <= term;
         last <= term & (seq_q == LAST_IDX);
         if (term) begin
            idx   <= seq_q;
            seq_q <= (seq_q == LAST_IDX) ? '0 : seq_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/twi_rate_gen.sv
module twi_rate_gen #(
   parameter int unsigned CFG_W      = 8,
   parameter int unsigned N_W        = 3,
   parameter int unsigned M_W        = 4,
   parameter int unsigned OVERSAMPLE = 10,
   parameter bit          ALT_EN     = 1'b1,
   parameter logic [CFG_W-1:0] RST_CFG = '0,
   parameter int unsigned PH_W       = $clog2(OVERSAMPLE)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             alt_mode,
   input  logic             cfg_we,
   input  logic [CFG_W-1:0] cfg_wdata,
   output logic             phase_stb,
   output logic [PH_W-1:0]  phase_idx,
   output logic             period_stb
);
   import twi_rate_pkg::*;

   localparam int unsigned M_LSB   = EXP_LSB + N_W;
   localparam int unsigned FIELD_W = N_W + M_W;

   generate
      if (CFG_W < FIELD_W) begin : g_bad_cfg_w
         $error("setting register too narrow for its fields");
      end
      if (OVERSAMPLE < 2) begin : g_bad_os
         $error("oversampling must be at least two");
      end
      if (N_W > 4) begin : g_bad_nw
         $error("exponent width makes the prescaler too wide");
      end
      if (CFG_W > FIELD_W) begin : g_spare_bits
         logic unused_hi;
         assign unused_hi = ^cfg_wdata[CFG_W-1:FIELD_W];
      end
   endgenerate

   logic [N_W-1:0] exp_q;
   logic [M_W-1:0] mant_q;
   logic           clr;
   logic           pre_tick;
   logic           mant_term;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         exp_q  <= RST_CFG[EXP_LSB +: N_W];
         mant_q <= RST_CFG[M_LSB +: M_W];
      end else if (cfg_we) begin
         exp_q  <= cfg_wdata[EXP_LSB +: N_W];
         mant_q <= cfg_wdata[M_LSB +: M_W];
      end
   end

   assign clr = cfg_we | ~enable;

   twi_rate_prescale #(.N_W(N_W), .ALT_EN(ALT_EN)) u_pre (
      .clk(clk), .rst_n(rst_n), .clr(clr), .alt_mode(alt_mode),
      .exp_n(exp_q), .tick(pre_tick)
   );

   twi_rate_mant #(.M_W(M_W)) u_mant (
      .clk(clk), .rst_n(rst_n), .clr(clr), .tick(pre_tick),
      .mant(mant_q), .term(mant_term)
   );

   twi_rate_phase #(.OVERSAMPLE(OVERSAMPLE), .PH_W(PH_W)) u_phase (
      .clk(clk), .rst_n(rst_n), .clr(clr), .term(mant_term),
      .stb(phase_stb), .idx(phase_idx), .last(period_stb)
   );
endmodule

// File: rtl/twi_rate_gen_chk.sv
module twi_rate_gen_chk #(
   parameter int unsigned OVERSAMPLE = 10,
   parameter int unsigned PH_W       = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            enable,
   input logic            cfg_we,
   input logic            phase_stb,
   input logic [PH_W-1:0] phase_idx,
   input logic            period_stb
);
   // R1
   quiet_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!phase_stb && !period_stb));

   // R5
   no_strobe_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> !phase_stb);

   // R6
   no_strobe_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (!phase_stb && !period_stb));

   // R7
   end_pulse_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      period_stb |-> phase_stb);

   // R7
   end_pulse_last_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
      period_stb |-> (phase_idx == PH_W'(OVERSAMPLE - 1)));

   // R7
   index_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phase_idx < PH_W'(OVERSAMPLE));
endmodule

bind twi_rate_gen twi_rate_gen_chk #(.OVERSAMPLE(OVERSAMPLE), .PH_W(PH_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_we(cfg_we),
   .phase_stb(phase_stb), .phase_idx(phase_idx), .period_stb(period_stb)
);

// File: tb/sim_twi_rate_gen.sv
module sim_twi_rate_gen;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       enable = 1'b0;
   logic       alt_mode = 1'b0;
   logic       cfg_we = 1'b0;
   logic [7:0] cfg_wdata = 8'h00;
   logic       phase_stb;
   logic [3:0] phase_idx;
   logic       period_stb;

   twi_rate_gen u0 (
      .clk(clk), .rst_n(rst_n), .enable(enable), .alt_mode(alt_mode),
      .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .phase_stb(phase_stb),
      .phase_idx(phase_idx), .period_stb(period_stb)
   );

   always #4 clk = ~clk;

   int    n_chk = 0;
   int    n_bad = 0;
   int    cyc = 0;
   string cur_req = "R1";

   // arithmetic reference model
   int m_r = 0, n_r = 0, cnt = 0, ph = 0, n_stb = 0;
   logic e_stb = 1'b0, e_last = 1'b0;
   int   e_idx = 0;

   function automatic int div_of(int m, int n, logic alt);
      return (m + 1) * (alt ? (1 << n) : (1 << (n + 1)));
   endfunction

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (!rst_n) begin
         m_r <= 0; n_r <= 0; cnt <= 0; ph <= 0;
         e_stb <= 1'b0; e_last <= 1'b0; e_idx <= 0;
      end else if (cfg_we) begin
         m_r <= int'(cfg_wdata[6:3]); n_r <= int'(cfg_wdata[2:0]);
         cnt <= 0; ph <= 0; e_stb <= 1'b0; e_last <= 1'b0;
      end else if (!enable) begin
         cnt <= 0; ph <= 0; e_stb <= 1'b0; e_last <= 1'b0;
      end else if (cnt + 1 == div_of(m_r, n_r, alt_mode)) begin
         e_stb <= 1'b1; e_idx <= ph; e_last <= (ph == 9);
         ph <= (ph == 9) ? 0 : ph + 1;
         cnt <= 0; n_stb <= n_stb + 1;
      end else begin
         cnt <= cnt + 1; e_stb <= 1'b0; e_last <= 1'b0;
      end
   end

   // cycle-by-cycle comparison, sampled away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         n_chk++;
         if (phase_stb !== e_stb || period_stb !== e_last ||
             (e_stb && int'(phase_idx) != e_idx)) begin
            n_bad++;
            $display("FAIL %s cyc=%0d stb/idx/last actual %0b/%0d/%0b expected %0b/%0d/%0b",
                     cur_req, cyc, phase_stb, phase_idx, period_stb, e_stb, e_idx, e_last);
         end
      end
   end

   task automatic write_cfg(input logic [7:0] d);
      @(negedge clk); cfg_we = 1'b1; cfg_wdata = d;
      @(negedge clk); cfg_we = 1'b0;
   endtask

   task automatic wait_strobes(input int k);
      int start = n_stb;
      while (n_stb < start + k) @(negedge clk);
   endtask

   task automatic run_cfg(input int m, input int n, input int k);
      write_cfg({1'b0, 4'(m), 3'(n)});
      wait_strobes(k);
   endtask

   task automatic measure_bit(input int expect_cyc);
      int t0;
      while (period_stb !== 1'b1) @(negedge clk);
      t0 = cyc;
      @(negedge clk);
      while (period_stb !== 1'b1) @(negedge clk);
      n_chk++;
      if (cyc - t0 != expect_cyc) begin
         n_bad++;
         $display("FAIL R8 bit period actual %0d expected %0d", cyc - t0, expect_cyc);
      end
   endtask

   initial begin
      // R1: outputs quiet under reset
      repeat (3) @(negedge clk);
      n_chk++;
      if (phase_stb !== 1'b0 || period_stb !== 1'b0 || phase_idx !== 4'd0) begin
         n_bad++;
         $display("FAIL R1 reset outputs actual %0b/%0d/%0b expected 0/0/0",
                  phase_stb, phase_idx, period_stb);
      end
      rst_n = 1'b1;
      @(negedge clk); enable = 1'b1;
      cur_req = "R1";
      wait_strobes(3);

      // R3: default exponent base sweep
      cur_req = "R3";
      for (int n = 0; n < 4; n++)
         for (int m = 0; m < 16; m++) run_cfg(m, n, 2);
      for (int n = 4; n < 8; n++) begin
         run_cfg(0, n, 2);
         run_cfg(15, n, 2);
      end

      // R4: direct exponent base sweep
      cur_req = "R4";
      @(negedge clk); enable = 1'b0; alt_mode = 1'b1;
      @(negedge clk); enable = 1'b1;
      for (int n = 0; n < 4; n++)
         for (int m = 0; m < 16; m++) run_cfg(m, n, 2);
      for (int n = 4; n < 8; n++) begin
         run_cfg(0, n, 2);
         run_cfg(15, n, 2);
      end

      // R2: bit 7 set, fields decoded from [2:0] and [6:3]
      cur_req = "R2";
      write_cfg(8'hFF);
      wait_strobes(1);
      write_cfg(8'b1_0010_011);
      wait_strobes(3);

      // R5: writes in the middle of a period
      cur_req = "R5";
      @(negedge clk); enable = 1'b0; alt_mode = 1'b0;
      @(negedge clk); enable = 1'b1;
      run_cfg(7, 2, 1);
      repeat (30) @(negedge clk);
      write_cfg({1'b0, 4'd7, 3'd2});
      repeat (17) @(negedge clk);
      write_cfg({1'b0, 4'd3, 3'd1});
      wait_strobes(3);

      // R6: enable dropped mid-period, then restored
      cur_req = "R6";
      repeat (5) @(negedge clk);
      enable = 1'b0;
      repeat (20) @(negedge clk);
      enable = 1'b1;
      wait_strobes(2);

      // R7: long run through several index wraps
      cur_req = "R7";
      run_cfg(1, 0, 35);

      // R8: bit period at the near-100 kHz setting, then the largest divisor
      cur_req = "R8";
      write_cfg({1'b0, 4'd15, 3'd2});
      measure_bit(1280);
      write_cfg({1'b0, 4'd0, 3'd0});
      measure_bit(20);
      cur_req = "R3";
      run_cfg(15, 7, 2);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (195000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual timeout expected completion (%s)", cur_req);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule